// File: doc/BRIEF.md
# Multi-Channel Transceiver Reset Sequencer

This block brings a group of transceiver channels out of reset in a fixed order and lets software restart or override that order afterwards. After the management reset is released, it holds the PLL powered down for a programmable number of clock cycles that stands for 1 ms. It then waits for every transmit PLL to lock and releases the transmit digital reset. Next it waits for clock-data recovery to lock to incoming data on every selected channel, and then releases the receive analog and digital resets. Ready flags report when each direction has come out of reset.

Software works through a 32-bit word-addressed register port with a one-cycle waitrequest on every access. The port gives access to four things. A channel select mask decides which channels any reset reaches. A trigger register restarts the transmit or receive digital reset, and reading the same register returns the ready flags. A manual register drives each reset line directly until software clears it. A read-only word shows the PLL lock inputs. Lock indications are plain input bits. The block contains no analog model.

Top module: `xcvr_rst_ctrl`

## Requirements
- R1: Every read or write keeps `waitreq` high for exactly its first cycle and low in its second cycle. A write takes effect at the end of the second cycle, and `rdata` holds the read value during that second cycle.
- R2: The mask register at word address 0x011 is read-write and one bit wide per channel. It resets to all ones, and bits at or above NUM_CH read as 0.
- R3: A write to an address other than 0x011, 0x012 or 0x013 changes nothing. A read from any address other than 0x010 through 0x013 returns 0.
- R4: While `mgmt_rst` is high: `pll_pd_o` is 1, every channel's TX digital, RX analog and RX digital reset is 1, both ready flags are 0, the mask is all ones and the manual register is 0. When `mgmt_rst` falls, the power-on sequence starts again.
- R5: After `mgmt_rst` falls, `pll_pd_o` stays high for exactly PD_CYCLES rising clock edges and then drops.
- R6: The TX digital reset is released, and `tx_ready_o` is set, only after power-down ends and every bit of `pll_locked` is 1. Reading word 0x010 returns `pll_locked`, with bit p for PLL p.
- R7: The RX analog and RX digital resets are released, and `rx_ready_o` is set, one edge after `tx_ready_o` is 1 and `cdr_locked` is 1 on every channel whose mask bit is 1. The CDR state of unmasked channels is ignored.
- R8: Writing bit 0 = 1 to word 0x012 asserts TX digital reset and clears `tx_ready_o` until every PLL is locked. Writing bit 1 = 1 asserts RX digital reset only, with no RX analog reset, and clears `rx_ready_o` until the R7 condition holds.
- R9: Reading word 0x012 returns `tx_ready_o` in bit 0 and `rx_ready_o` in bit 1.
- R10: The manual register at word 0x013 is read-write. Bit 3 forces RX digital reset, bit 2 forces RX analog reset, bit 1 forces TX digital reset and bit 0 forces `pll_pd_o`. Each line stays forced until a 0 is written to its bit. The manual bits do not change the ready flags.
- R11: A channel whose mask bit is 0 never has its TX digital, RX analog or RX digital reset driven high, whether by a trigger or by manual control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management and sequencer clock |
| mgmt_rst | input | 1 | Active-high, level-sensitive reset of the whole block |
| addr | input | 9 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `waitreq` is low |
| wr | input | 1 | Write request |
| rd | input | 1 | Read request |
| waitreq | output | 1 | High during the first cycle of each access |
| pll_locked | input | NUM_PLL | Per-PLL lock indication |
| cdr_locked | input | NUM_CH | Per-channel CDR locked-to-data indication |
| pll_pd_o | output | 1 | PLL power-down |
| tx_dig_rst_o | output | NUM_CH | Per-channel TX digital reset |
| rx_ana_rst_o | output | NUM_CH | Per-channel RX analog reset |
| rx_dig_rst_o | output | NUM_CH | Per-channel RX digital reset |
| tx_ready_o | output | 1 | TX side out of reset |
| rx_ready_o | output | 1 | RX side out of reset |

## Verification
The port checks assume that a master keeps its request, address and data steady through the waitrequest cycle, and raises only one of `rd` and `wr` at a time. The bench's access task drives both edges of every access at the falling clock edge. It holds the request for exactly two cycles and drops it right after the completing edge, so no access overlaps another. Lock inputs are treated as already synchronous, so the bench changes them only at falling edges. Sequencing checks therefore count whole edges from each change.

// File: rtl/xcvr_rst_pkg.sv
package xcvr_rst_pkg;

   localparam int unsigned ADDR_W = 9;
   localparam int unsigned DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_PLL_STAT = 9'h010;
   localparam logic [ADDR_W-1:0] A_CH_MASK  = 9'h011;
   localparam logic [ADDR_W-1:0] A_TRIGGER  = 9'h012;
   localparam logic [ADDR_W-1:0] A_MANUAL   = 9'h013;

   // bit positions inside the manual register
   localparam int unsigned M_PD  = 0;
   localparam int unsigned M_TXD = 1;
   localparam int unsigned M_RXA = 2;
   localparam int unsigned M_RXD = 3;

   typedef struct packed {
      logic pd;
      logic txd;
      logic rxa;
      logic rxd;
   } rst_lines_t;

endpackage

// File: rtl/rst_csr.sv
module rst_csr
   import xcvr_rst_pkg::*;
#(
   parameter int unsigned NUM_CH  = 32,
   parameter int unsigned NUM_PLL = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                wr,
   input  logic                rd,
   output logic [DATA_W-1:0]   rdata,
   output logic                waitreq,
   input  logic [NUM_PLL-1:0]  pll_locked,
   input  logic                tx_ready,
   input  logic                rx_ready,
   output logic [NUM_CH-1:0]   mask,
   output rst_lines_t          man,
   output logic                tx_trig,
   output logic                rx_trig
);

   logic              ack_q;
   logic              req;
   logic              commit_wr;
   logic [DATA_W-1:0] rd_mux;
   logic [3:0]        man_q;
   logic              unused_wdata;

   assign req       = rd | wr;
   assign waitreq   = req & ~ack_q;
   assign commit_wr = wr & ack_q;
   assign unused_wdata = ^wdata;

   always_comb begin
      rd_mux = '0;
      case (addr)
         A_PLL_STAT: rd_mux = DATA_W'(pll_locked);
         A_CH_MASK:  rd_mux = DATA_W'(mask);
         A_TRIGGER:  rd_mux = DATA_W'({rx_ready, tx_ready});
         A_MANUAL:   rd_mux = DATA_W'(man_q);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q <= 1'b0;
         rdata <= '0;
      end else if (req && !ack_q) begin
         ack_q <= 1'b1;
         rdata <= rd_mux;
      end else begin
         ack_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mask  <= '1;
         man_q <= '0;
      end else if (commit_wr) begin
         if (addr == A_CH_MASK) mask  <= wdata[NUM_CH-1:0];
         if (addr == A_MANUAL)  man_q <= wdata[3:0];
      end
   end

   assign tx_trig = commit_wr && (addr == A_TRIGGER) && wdata[0];
   assign rx_trig = commit_wr && (addr == A_TRIGGER) && wdata[1];

   assign man.pd  = man_q[M_PD];
   assign man.txd = man_q[M_TXD];
   assign man.rxa = man_q[M_RXA];
   assign man.rxd = man_q[M_RXD];

   AST_WAIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      waitreq |=> !waitreq) else $error("waitreq longer than one cycle"); // R1
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
      waitreq |=> (req && $stable(addr) && $stable(wdata))) else $error("request dropped in wait"); // R1
   AST_MASK_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mask == '1 && man_q == '0)) else $error("reset values wrong"); // R4

endmodule

// File: rtl/rst_seq.sv
module rst_seq
   import xcvr_rst_pkg::*;
#(
   parameter int unsigned PD_CYCLES = 100000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tx_trig,
   input  logic       rx_trig,
   input  logic       pll_ok,
   input  logic       cdr_ok,
   output rst_lines_t lines,
   output logic       tx_ready,
   output logic       rx_ready
);

   localparam int unsigned CW = (PD_CYCLES < 2) ? 1 : $clog2(PD_CYCLES);
   localparam logic [CW-1:0] CNT_LAST = CW'(PD_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          pd_q, tx_q, rxa_q, rxd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         pd_q     <= 1'b1;
         tx_q     <= 1'b1;
         rxa_q    <= 1'b1;
         rxd_q    <= 1'b1;
         tx_ready <= 1'b0;
         rx_ready <= 1'b0;
      end else begin
         if (pd_q) begin
            if (cnt_q == CNT_LAST) pd_q <= 1'b0;
            else cnt_q <= cnt_q + 1'b1;
         end
         if (tx_q && !pd_q && pll_ok) begin
            tx_q     <= 1'b0;
            tx_ready <= 1'b1;
         end
         if ((rxa_q || rxd_q) && tx_ready && cdr_ok) begin
            rxa_q    <= 1'b0;
            rxd_q    <= 1'b0;
            rx_ready <= 1'b1;
         end
         if (tx_trig) begin
            tx_q     <= 1'b1;
            tx_ready <= 1'b0;
         end
         if (rx_trig) begin
            rxd_q    <= 1'b1;
            rx_ready <= 1'b0;
         end
      end
   end

   assign lines.pd  = pd_q;
   assign lines.txd = tx_q;
   assign lines.rxa = rxa_q;
   assign lines.rxd = rxd_q;

   AST_PD_BLOCKS_TX: assert property (@(posedge clk) disable iff (rst)
      pd_q |-> !tx_ready) else $error("tx ready during power-down"); // R5
   AST_TX_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_ready) |-> $past(pll_ok)) else $error("tx ready without pll lock"); // R6
   AST_RX_NEEDS_CDR: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_ready) |-> $past(cdr_ok && tx_ready)) else $error("rx ready without cdr lock"); // R7

endmodule

// File: rtl/rst_lanes.sv
module rst_lanes
   import xcvr_rst_pkg::*;
#(
   parameter int unsigned NUM_CH = 32
) (
   input  rst_lines_t        seq,
   input  rst_lines_t        man,
   input  logic [NUM_CH-1:0] mask,
   output logic              pll_pd,
   output logic [NUM_CH-1:0] txd,
   output logic [NUM_CH-1:0] rxa,
   output logic [NUM_CH-1:0] rxd
);

   rst_lines_t any;

   assign any    = seq | man;
   assign pll_pd = any.pd;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      assign txd[ch] = mask[ch] & any.txd;
      assign rxa[ch] = mask[ch] & any.rxa;
      assign rxd[ch] = mask[ch] & any.rxd;
   end

endmodule

// File: rtl/xcvr_rst_ctrl.sv
module xcvr_rst_ctrl
   import xcvr_rst_pkg::*;
#(
   parameter int unsigned NUM_CH    = 32,
   parameter int unsigned NUM_PLL   = 1,
   parameter int unsigned PD_CYCLES = 100000
) (
   input  logic                clk,
   input  logic                mgmt_rst,
   input  logic [8:0]          addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   input  logic                wr,
   input  logic                rd,
   output logic                waitreq,
   input  logic [NUM_PLL-1:0]  pll_locked,
   input  logic [NUM_CH-1:0]   cdr_locked,
   output logic                pll_pd_o,
   output logic [NUM_CH-1:0]   tx_dig_rst_o,
   output logic [NUM_CH-1:0]   rx_ana_rst_o,
   output logic [NUM_CH-1:0]   rx_dig_rst_o,
   output logic                tx_ready_o,
   output logic                rx_ready_o
);

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must be 1..32");
   end
   if (NUM_PLL < 1 || NUM_PLL > DATA_W) begin : g_bad_pll
      $error("NUM_PLL must be 1..32");
   end
   if (PD_CYCLES < 1) begin : g_bad_pd
      $error("PD_CYCLES must be at least 1");
   end

   logic [NUM_CH-1:0] mask;
   rst_lines_t        man, seq;
   logic              tx_trig, rx_trig;
   logic              pll_ok, cdr_ok;

   assign pll_ok = &pll_locked;
   assign cdr_ok = &(cdr_locked | ~mask);

   rst_csr #(.NUM_CH(NUM_CH), .NUM_PLL(NUM_PLL)) u_csr (
      .clk(clk), .rst(mgmt_rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
      .rdata(rdata), .waitreq(waitreq), .pll_locked(pll_locked),
      .tx_ready(tx_ready_o), .rx_ready(rx_ready_o), .mask(mask), .man(man),
      .tx_trig(tx_trig), .rx_trig(rx_trig)
   );

   rst_seq #(.PD_CYCLES(PD_CYCLES)) u_seq (
      .clk(clk), .rst(mgmt_rst), .tx_trig(tx_trig), .rx_trig(rx_trig),
      .pll_ok(pll_ok), .cdr_ok(cdr_ok), .lines(seq),
      .tx_ready(tx_ready_o), .rx_ready(rx_ready_o)
   );

   rst_lanes #(.NUM_CH(NUM_CH)) u_lanes (
      .seq(seq), .man(man), .mask(mask), .pll_pd(pll_pd_o),
      .txd(tx_dig_rst_o), .rxa(rx_ana_rst_o), .rxd(rx_dig_rst_o)
   );

endmodule

// File: tb/xcvr_rst_ctrl_test.sv
module xcvr_rst_ctrl_test;

   localparam int NCH = 4;
   localparam int NPL = 2;
   localparam int PD  = 16;

   logic        clk = 1'b0;
   logic        mgmt_rst = 1'b1;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        wr = 1'b0, rd = 1'b0, waitreq;
   logic [NPL-1:0] pll_locked = '0;
   logic [NCH-1:0] cdr_locked = '0;
   logic        pll_pd_o, tx_ready_o, rx_ready_o;
   logic [NCH-1:0] tx_dig_rst_o, rx_ana_rst_o, rx_dig_rst_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   xcvr_rst_ctrl #(.NUM_CH(NCH), .NUM_PLL(NPL), .PD_CYCLES(PD)) uut (
      .clk(clk), .mgmt_rst(mgmt_rst), .addr(addr), .wdata(wdata), .rdata(rdata),
      .wr(wr), .rd(rd), .waitreq(waitreq), .pll_locked(pll_locked),
      .cdr_locked(cdr_locked), .pll_pd_o(pll_pd_o), .tx_dig_rst_o(tx_dig_rst_o),
      .rx_ana_rst_o(rx_ana_rst_o), .rx_dig_rst_o(rx_dig_rst_o),
      .tx_ready_o(tx_ready_o), .rx_ready_o(rx_ready_o)
   );

   // {is_write, address, data-or-expected}
   localparam int NV = 11;
   localparam logic [41:0] VEC [NV] = '{
      {1'b0, 9'h011, 32'h0000_000F},   // R2 mask default, upper bits zero
      {1'b1, 9'h011, 32'hFFFF_FFF5},   // R2 select channels 0 and 2
      {1'b0, 9'h011, 32'h0000_0005},   // R2
      {1'b0, 9'h010, 32'h0000_0003},   // R6 PLL status
      {1'b0, 9'h012, 32'h0000_0003},   // R9 both ready
      {1'b1, 9'h1FF, 32'hFFFF_FFFF},   // R3 undefined write
      {1'b0, 9'h1FF, 32'h0000_0000},   // R3 undefined read
      {1'b0, 9'h011, 32'h0000_0005},   // R3 mask untouched
      {1'b0, 9'h000, 32'h0000_0000},   // R3
      {1'b1, 9'h013, 32'h0000_00F0},   // R10 only low four bits exist
      {1'b0, 9'h013, 32'h0000_0000}    // R10
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic is_wr, input logic [8:0] a, input logic [31:0] d,
                         output logic [31:0] rv);
      addr = a; wdata = d; wr = is_wr; rd = ~is_wr;
      #1;
      chk("R1 wait high", 32'(waitreq), 32'd1);
      @(posedge clk); @(negedge clk);
      chk("R1 wait low", 32'(waitreq), 32'd0);
      rv = rdata;
      @(posedge clk); @(negedge clk);
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
      logic [31:0] rv;
      access(1'b1, a, d, rv);
   endtask

   task automatic bus_rd(input logic [8:0] a, input logic [31:0] exp, input string req);
      logic [31:0] rv;
      access(1'b0, a, 32'h0, rv);
      chk(req, rv, exp);
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      edges(3);
      // R4 reset state
      chk("R4 pd", 32'(pll_pd_o), 32'd1);
      chk("R4 txd", 32'(tx_dig_rst_o), 32'hF);
      chk("R4 rxa/rxd", 32'({rx_ana_rst_o, rx_dig_rst_o}), 32'hFF);
      chk("R4 ready", 32'({rx_ready_o, tx_ready_o}), 32'd0);
      mgmt_rst = 1'b0;
      // R5 power-down length
      edges(PD - 1);
      chk("R5 pd held", 32'(pll_pd_o), 32'd1);
      edges(1);
      chk("R5 pd released", 32'(pll_pd_o), 32'd0);
      // R6 partial PLL lock keeps TX in reset
      pll_locked = 2'b01;
      edges(3);
      chk("R6 partial lock ready", 32'(tx_ready_o), 32'd0);
      chk("R6 partial lock txd", 32'(tx_dig_rst_o), 32'hF);
      pll_locked = 2'b11;
      edges(1);
      chk("R6 ready", 32'(tx_ready_o), 32'd1);
      chk("R6 txd released", 32'(tx_dig_rst_o), 32'h0);
      // R7 one CDR unlocked keeps RX in reset
      cdr_locked = 4'b0111;
      edges(3);
      chk("R7 partial cdr", 32'(rx_ready_o), 32'd0);
      chk("R7 rxa held", 32'(rx_ana_rst_o), 32'hF);
      cdr_locked = 4'b1111;
      edges(1);
      chk("R7 ready", 32'(rx_ready_o), 32'd1);
      chk("R7 rx released", 32'({rx_ana_rst_o, rx_dig_rst_o}), 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][41]) bus_wr(VEC[i][40:32], VEC[i][31:0]);
         else            bus_rd(VEC[i][40:32], VEC[i][31:0], "R2/R3/R9 vector read");
      end
      chk("R3 outputs quiet", 32'({tx_dig_rst_o, rx_ana_rst_o, rx_dig_rst_o, pll_pd_o}), 32'h0);

      // R8/R11 TX trigger, mask 0101
      pll_locked = 2'b00;
      bus_wr(9'h012, 32'h1);
      chk("R8 R11 tx trigger lanes", 32'(tx_dig_rst_o), 32'h5);
      chk("R8 tx ready cleared", 32'(tx_ready_o), 32'd0);
      bus_rd(9'h012, 32'h2, "R9 tx not ready");
      pll_locked = 2'b11;
      edges(1);
      chk("R8 tx recovers", 32'({tx_ready_o, tx_dig_rst_o}), 32'h10);

      // R8 RX trigger: digital only; R7 unmasked CDR ignored
      cdr_locked = 4'b0000;
      bus_wr(9'h012, 32'h2);
      chk("R8 R11 rx digital lanes", 32'(rx_dig_rst_o), 32'h5);
      chk("R8 rx analog untouched", 32'(rx_ana_rst_o), 32'h0);
      chk("R8 rx ready cleared", 32'(rx_ready_o), 32'd0);
      cdr_locked = 4'b0101;
      edges(1);
      chk("R7 masked cdr only", 32'({rx_ready_o, rx_dig_rst_o}), 32'h10);

      // R10 manual control
      bus_wr(9'h013, 32'h2);
      edges(4);
      chk("R10 R11 manual txd", 32'(tx_dig_rst_o), 32'h5);
      chk("R10 manual pd off", 32'(pll_pd_o), 32'd0);
      chk("R10 ready kept", 32'({rx_ready_o, tx_ready_o}), 32'h3);
      bus_rd(9'h013, 32'h2, "R10 readback");
      bus_wr(9'h013, 32'h0);
      chk("R10 txd cleared", 32'(tx_dig_rst_o), 32'h0);
      bus_wr(9'h013, 32'h1);
      chk("R10 manual pd", 32'(pll_pd_o), 32'd1);
      bus_wr(9'h013, 32'hC);
      chk("R10 manual rx", 32'({pll_pd_o, rx_ana_rst_o, rx_dig_rst_o}), 32'h55);
      bus_wr(9'h013, 32'h0);
      chk("R10 all clear", 32'({pll_pd_o, rx_ana_rst_o, rx_dig_rst_o, tx_dig_rst_o}), 32'h0);

      // R4 management reset mid-operation restarts the sequence
      mgmt_rst = 1'b1;
      edges(2);
      chk("R4 rerun pd", 32'(pll_pd_o), 32'd1);
      chk("R4 rerun txd", 32'(tx_dig_rst_o), 32'hF);
      chk("R4 rerun ready", 32'({rx_ready_o, tx_ready_o}), 32'h0);
      mgmt_rst = 1'b0;
      bus_rd(9'h011, 32'hF, "R4 mask restored");
      edges(PD + 4);
      chk("R6 tx after rerun", 32'(tx_ready_o), 32'd1);
      chk("R7 mask all, cdr partial", 32'(rx_ready_o), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule